// File: doc/BRIEF.md
# Processor Status and Reset-Cause Register

This block is the 8-bit status and control register of a small microcontroller. It records whether the CPU is running or halted, whether interrupts are enabled, and whether the device is in its low-power suspend state. It also records which kind of reset happened last and whether a qualified bus event has been seen. The CPU core reads the register on `rd_data` and writes it through `wr_en`/`wr_data`. Dedicated strobes from the instruction decoder report halt, interrupt disable, interrupt enable and return-from-interrupt.

The block contains three timers, all of which count pulses on a slow timebase input `tick`. The first is a watchdog that resets the CPU when firmware stops kicking it. The second is a duration qualifier that turns a long bus condition into a sticky event flag. The third is a clock-startup delay used when the device leaves suspend. A watchdog expiry acts as a synchronous reset of this block, and it keeps some flags that a power-on reset clears. Entering suspend drives `clk_stop_req`. A wake condition then releases the clock request and counts out the startup delay before the CPU resumes.

Top module: `cpu_stat_ctrl`

## Requirements
- R1: The register bits from bit 0 to bit 7 are: run, reserved, interrupt-enable sense, suspend, low-voltage/power-on cause, bus event, watchdog cause, IRQ pending. While `por_n` is low the register reads 0x11. Bit 1 always reads 0 whatever is written.
- R2: A `halt_stb` pulse, or a write with bit 0 at 0, clears the run bit. `cpu_halt` is high while the run bit is 0. Only a reset sets the run bit again, and writing 1 to bit 0 does not.
- R3: `di_stb` clears bit 2 and `ei_stb` or `reti_stb` sets it. `di_stb` wins when it arrives in the same cycle as either of the others. Register writes leave bit 2 unchanged.
- R4: A write with bit 3 at 1, made while the device is running, enters suspend. From the next cycle `clk_stop_req`, bit 3 and `cpu_halt` are all 1.
- R5: While the clock is stopped, `wake_irq` or `wake_bus` drops `clk_stop_req` on the next cycle. Bit 3 and `cpu_halt` stay high until START_TICKS further ticks have arrived, and then both clear. If a wake condition is already present when suspend is written, `clk_stop_req` is high for exactly one cycle.
- R6: The watchdog expires on the WDT_TICKS-th tick with no `wdt_kick`. In the same edge it loads bits 7,6,3,2,1,0 with 0,1,0,0,0,1 and keeps bits 5 and 4.
- R7: `wdt_kick` restarts the watchdog count, and a kick in the same cycle as a tick wins over the tick. When WDT_HOLD_IN_SLEEP is 1, ticks are not counted while `clk_stop_req` is high.
- R8: Bit 5 sets on the QUAL_TICKS-th tick of an unbroken `bus_cond` high, regardless of interrupt enable. Dropping `bus_cond` restarts the count. Each unbroken condition sets the bit at most once.
- R9: Writing 0 to bit 4, 5 or 6 clears that bit, and writing 1 leaves it unchanged. A bus event set in the same cycle as a write clearing bit 5 leaves bit 5 at 1.
- R10: `irq_req` while bit 2 is 0 sets bit 7. `irq_req` while bit 2 is 1 does not set it. `irq_take` clears bit 7. Writes leave bit 7 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on / low-voltage reset, active low, asynchronous |
| tick | input | 1 | Slow timebase pulse, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register value |
| halt_stb | input | 1 | Halt instruction executed |
| di_stb | input | 1 | Interrupt disable executed |
| ei_stb | input | 1 | Interrupt enable executed |
| reti_stb | input | 1 | Return from interrupt executed |
| wdt_kick | input | 1 | Watchdog clear |
| bus_cond | input | 1 | Raw bus condition to be qualified |
| irq_req | input | 1 | An interrupt has been recognized |
| irq_take | input | 1 | Interrupt entry sequence takes the interrupt |
| wake_irq | input | 1 | Pending enabled interrupt, wake source |
| wake_bus | input | 1 | Bus activity, wake source |
| cpu_halt | output | 1 | CPU must not execute |
| clk_stop_req | output | 1 | Request to stop the oscillator |

## Verification
Two pairs of events can fall on the same clock edge. The first is a bus-event set and a firmware write clearing bit 5. The bench brings the qualifier to one tick short of its limit and then issues the clearing write in the tick cycle, so bit 5 must read 1. The second is a watchdog expiry and a bus-event set. The bench offsets the start of `bus_cond` so that both counters reach their limits on the same tick, and the whole register must then read the watchdog value with bit 5 set.

// File: rtl/cpu_stat_pkg.sv
package cpu_stat_pkg;
   localparam int REG_W    = 8;
   localparam int BIT_RUN  = 0;
   localparam int BIT_RSVD = 1;
   localparam int BIT_IE   = 2;
   localparam int BIT_SUSP = 3;
   localparam int BIT_LVR  = 4;
   localparam int BIT_BUS  = 5;
   localparam int BIT_WDR  = 6;
   localparam int BIT_IRQ  = 7;

   typedef enum logic [1:0] {
      SQ_RUN   = 2'd0,
      SQ_STOP  = 2'd1,
      SQ_START = 2'd2
   } sq_state_t;
endpackage

// File: rtl/tick_timeout.sv
// Counts timebase ticks while run is high; hit pulses on the LIMIT-th tick.
// ONE_SHOT=1 holds after the hit until clr; ONE_SHOT=0 restarts from zero.
module tick_timeout #(
   parameter int LIMIT    = 4,
   parameter bit ONE_SHOT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic run,
   input  logic clr,
   output logic hit
);
   localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   if (LIMIT < 2) begin : g_bad_limit
      $error("tick_timeout: LIMIT must be at least 2");
   end

   logic [CW-1:0] cnt_q;
   logic          done;
   logic          adv;
   logic          at_last;

   assign at_last = (cnt_q == LAST);
   assign adv     = tick && run && !clr && !done;
   assign hit     = adv && at_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (clr)     cnt_q <= '0;
      else if (adv)     cnt_q <= at_last ? '0 : cnt_q + 1'b1;
   end

   if (ONE_SHOT) begin : g_one_shot
      logic done_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    done_q <= 1'b0;
         else if (clr)  done_q <= 1'b0;
         else if (hit)  done_q <= 1'b1;
      end
      assign done = done_q;
   end else begin : g_periodic
      assign done = 1'b0;
   end
endmodule

// File: rtl/suspend_seq.sv
// Suspend entry, clock stop and wake-with-startup-delay sequencer.
module suspend_seq
   import cpu_stat_pkg::*;
#(
   parameter int START_TICKS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic enter,
   input  logic wake,
   input  logic wdr,
   output logic clk_stop,
   output logic suspended
);
   sq_state_t state_q, state_d;
   logic      start_done;
   logic      in_start;

   assign in_start = (state_q == SQ_START);

   tick_timeout #(.LIMIT(START_TICKS), .ONE_SHOT(1'b1)) u_start_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .run   (in_start),
      .clr   (!in_start || wdr),
      .hit   (start_done)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SQ_RUN:   if (enter)      state_d = SQ_STOP;
         SQ_STOP:  if (wake)       state_d = SQ_START;
         SQ_START: if (start_done) state_d = SQ_RUN;
         default:                  state_d = SQ_RUN;
      endcase
      if (wdr) state_d = SQ_RUN;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SQ_RUN;
      else        state_q <= state_d;
   end

   assign clk_stop  = (state_q == SQ_STOP);
   assign suspended = (state_q != SQ_RUN);

   // R5: a wake seen with the clock stopped releases the clock request next cycle
   p_wake_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_stop && wake && !wdr) |=> !clk_stop)
      else $error("wake did not release clock stop");

   // R4: entry from run always passes through the stopped state
   p_enter_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!suspended && enter && !wdr) |=> clk_stop)
      else $error("suspend entry did not stop the clock");
endmodule

// File: rtl/cpu_stat_ctrl.sv
module cpu_stat_ctrl
   import cpu_stat_pkg::*;
#(
   parameter int WDT_TICKS         = 63,
   parameter int QUAL_TICKS        = 2,
   parameter int START_TICKS       = 8,
   parameter bit WDT_HOLD_IN_SLEEP = 1'b1
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             tick,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   input  logic             halt_stb,
   input  logic             di_stb,
   input  logic             ei_stb,
   input  logic             reti_stb,
   input  logic             wdt_kick,
   input  logic             bus_cond,
   input  logic             irq_req,
   input  logic             irq_take,
   input  logic             wake_irq,
   input  logic             wake_bus,
   output logic             cpu_halt,
   output logic             clk_stop_req
);
   if (REG_W != 8) begin : g_bad_width
      $error("cpu_stat_ctrl: register must be 8 bits wide");
   end

   logic run_q, ie_q, lvr_q, bus_q, wdr_q, irq_q;
   logic wdt_hit, bus_set, suspended, wdt_run;
   logic unused_wr_bits;

   assign unused_wr_bits = ^{wr_data[BIT_IRQ], wr_data[BIT_IE], wr_data[BIT_RSVD]};

   if (WDT_HOLD_IN_SLEEP) begin : g_wdt_hold
      assign wdt_run = !clk_stop_req;
      // R7: no watchdog expiry while the clock is stopped
      p_no_wdr_sleep_r7: assert property (@(posedge clk) disable iff (!por_n)
         clk_stop_req |-> !wdt_hit)
         else $error("watchdog expired with clock stopped");
   end else begin : g_wdt_free
      assign wdt_run = 1'b1;
   end

   tick_timeout #(.LIMIT(WDT_TICKS), .ONE_SHOT(1'b0)) u_wdt (
      .clk   (clk),
      .rst_n (por_n),
      .tick  (tick),
      .run   (wdt_run),
      .clr   (wdt_kick),
      .hit   (wdt_hit)
   );

   tick_timeout #(.LIMIT(QUAL_TICKS), .ONE_SHOT(1'b1)) u_bus_qual (
      .clk   (clk),
      .rst_n (por_n),
      .tick  (tick),
      .run   (bus_cond),
      .clr   (!bus_cond),
      .hit   (bus_set)
   );

   suspend_seq #(.START_TICKS(START_TICKS)) u_susp (
      .clk       (clk),
      .rst_n     (por_n),
      .tick      (tick),
      .enter     (wr_en && wr_data[BIT_SUSP]),
      .wake      (wake_irq || wake_bus),
      .wdr       (wdt_hit),
      .clk_stop  (clk_stop_req),
      .suspended (suspended)
   );

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         run_q <= 1'b1;
         ie_q  <= 1'b0;
         lvr_q <= 1'b1;
         bus_q <= 1'b0;
         wdr_q <= 1'b0;
         irq_q <= 1'b0;
      end else if (wdt_hit) begin
         run_q <= 1'b1;
         ie_q  <= 1'b0;
         wdr_q <= 1'b1;
         irq_q <= 1'b0;
         bus_q <= bus_q || bus_set;
      end else begin
         if (halt_stb || (wr_en && !wr_data[BIT_RUN])) run_q <= 1'b0;
         if (di_stb)                      ie_q <= 1'b0;
         else if (ei_stb || reti_stb)     ie_q <= 1'b1;
         if (wr_en && !wr_data[BIT_LVR])  lvr_q <= 1'b0;
         if (wr_en && !wr_data[BIT_WDR])  wdr_q <= 1'b0;
         if (bus_set)                     bus_q <= 1'b1;
         else if (wr_en && !wr_data[BIT_BUS]) bus_q <= 1'b0;
         if (irq_take)                    irq_q <= 1'b0;
         else if (irq_req && !ie_q)       irq_q <= 1'b1;
      end
   end

   always_comb begin
      rd_data           = '0;
      rd_data[BIT_RUN]  = run_q;
      rd_data[BIT_IE]   = ie_q;
      rd_data[BIT_SUSP] = suspended;
      rd_data[BIT_LVR]  = lvr_q;
      rd_data[BIT_BUS]  = bus_q;
      rd_data[BIT_WDR]  = wdr_q;
      rd_data[BIT_IRQ]  = irq_q;
   end

   assign cpu_halt = !run_q || suspended;

   // R2: run stays clear until a reset
   p_run_sticky_r2: assert property (@(posedge clk) disable iff (!por_n)
      (!rd_data[BIT_RUN] && !wdt_hit) |=> !rd_data[BIT_RUN])
      else $error("run bit set without reset");

   // R2: a halt strobe stops the CPU
   p_halt_stop_r2: assert property (@(posedge clk) disable iff (!por_n)
      (halt_stb && !wdt_hit) |=> cpu_halt)
      else $error("halt strobe did not halt");

   // R3: disable clears the enable sense
   p_di_clears_r3: assert property (@(posedge clk) disable iff (!por_n)
      di_stb |=> !rd_data[BIT_IE])
      else $error("interrupt disable ignored");

   // R4: a stopped clock implies a halted CPU and a visible suspend flag
   p_stop_halts_r4: assert property (@(posedge clk) disable iff (!por_n)
      clk_stop_req |-> (cpu_halt && rd_data[BIT_SUSP]))
      else $error("clock stopped while CPU not halted");

   // R6: watchdog load value, with both cause bits kept
   p_wdr_value_r6: assert property (@(posedge clk) disable iff (!por_n)
      wdt_hit |=> (((rd_data & 8'hCF) == 8'h41)
                   && (rd_data[BIT_LVR] == $past(rd_data[BIT_LVR]))
                   && (rd_data[BIT_BUS] || !$past(rd_data[BIT_BUS]))))
      else $error("wrong value after watchdog expiry");

   // R8: a qualified bus event is visible on the next cycle
   p_bus_set_r8: assert property (@(posedge clk) disable iff (!por_n)
      bus_set |=> rd_data[BIT_BUS])
      else $error("bus event lost");

   // R9: writing 1 to a cause bit keeps it
   p_wr_keeps_r9: assert property (@(posedge clk) disable iff (!por_n)
      (wr_en && wr_data[BIT_LVR] && !wdt_hit) |=> (rd_data[BIT_LVR] == $past(rd_data[BIT_LVR])))
      else $error("cause bit changed by writing 1");

   // R10: the interrupt entry sequence clears pending
   p_irq_take_r10: assert property (@(posedge clk) disable iff (!por_n)
      irq_take |=> !rd_data[BIT_IRQ])
      else $error("pending not cleared by take");
endmodule

// File: tb/test_cpu_stat_ctrl.sv
`timescale 1ns/1ps
module test_cpu_stat_ctrl;
   localparam int WDT   = 6;
   localparam int QUAL  = 3;
   localparam int START = 2;

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       halt_stb = 1'b0, di_stb = 1'b0, ei_stb = 1'b0, reti_stb = 1'b0;
   logic       wdt_kick = 1'b0, bus_cond = 1'b0, irq_req = 1'b0, irq_take = 1'b0;
   logic       wake_irq = 1'b0, wake_bus = 1'b0;
   logic       cpu_halt, clk_stop_req;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   cpu_stat_ctrl #(
      .WDT_TICKS(WDT), .QUAL_TICKS(QUAL), .START_TICKS(START), .WDT_HOLD_IN_SLEEP(1'b1)
   ) i_cpu_stat_ctrl (
      .clk(clk), .por_n(por_n), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .halt_stb(halt_stb), .di_stb(di_stb), .ei_stb(ei_stb),
      .reti_stb(reti_stb), .wdt_kick(wdt_kick), .bus_cond(bus_cond),
      .irq_req(irq_req), .irq_take(irq_take), .wake_irq(wake_irq),
      .wake_bus(wake_bus), .cpu_halt(cpu_halt), .clk_stop_req(clk_stop_req)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic do_wr(input logic [7:0] d);
      wr_en = 1'b1; wr_data = d; step(); wr_en = 1'b0;
   endtask

   task automatic do_tick(input int n);
      for (int i = 0; i < n; i++) begin
         tick = 1'b1; step(); tick = 1'b0;
      end
   endtask

   task automatic kick();
      wdt_kick = 1'b1; step(); wdt_kick = 1'b0;
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) step();
      por_n = 1'b1;
      step();
      check("R1 reset value", rd_data, 8'h11);
      check("R1 reset halt", cpu_halt, 1'b0);
      check("R1 reset clock", clk_stop_req, 1'b0);

      // R1/R3/R9: ones to reserved, enable sense and cause bits change nothing
      do_wr(8'h77);
      check("R1 reserved reads 0", rd_data, 8'h11);

      // R3 enable sense
      ei_stb = 1'b1; step(); ei_stb = 1'b0;
      check("R3 enable", rd_data, 8'h15);
      do_wr(8'h71);
      check("R3 write ignored", rd_data, 8'h15);
      di_stb = 1'b1; step(); di_stb = 1'b0;
      check("R3 disable", rd_data, 8'h11);
      reti_stb = 1'b1; step(); reti_stb = 1'b0;
      check("R3 return sets", rd_data, 8'h15);
      di_stb = 1'b1; ei_stb = 1'b1; step(); di_stb = 1'b0; ei_stb = 1'b0;
      check("R3 disable wins", rd_data, 8'h11);

      // R10 pending
      irq_req = 1'b1; step(); irq_req = 1'b0;
      check("R10 pending set", rd_data, 8'h91);
      do_wr(8'h71);
      check("R10 write 0 ignored", rd_data, 8'h91);
      irq_take = 1'b1; step(); irq_take = 1'b0;
      check("R10 take clears", rd_data, 8'h11);
      ei_stb = 1'b1; step(); ei_stb = 1'b0;
      irq_req = 1'b1; step(); irq_req = 1'b0;
      check("R10 not set when enabled", rd_data, 8'h15);
      di_stb = 1'b1; step(); di_stb = 1'b0;
      do_wr(8'hF1);
      check("R10 write 1 ignored", rd_data, 8'h11);

      // R9 clear low-voltage cause
      do_wr(8'h61);
      check("R9 clear bit4", rd_data, 8'h01);

      // R8 sweep of condition length
      for (int k = 0; k <= QUAL + 1; k++) begin
         do_wr(8'h51);
         kick();
         bus_cond = 1'b1;
         do_tick(k);
         check($sformatf("R8 length %0d", k), rd_data[5], (k >= QUAL) ? 1'b1 : 1'b0);
         bus_cond = 1'b0;
         step();
      end
      do_wr(8'h51);
      kick();
      bus_cond = 1'b1; do_tick(QUAL - 1);
      bus_cond = 1'b0; step();
      bus_cond = 1'b1; do_tick(QUAL - 1);
      check("R8 drop restarts", rd_data[5], 1'b0);
      do_tick(1);
      check("R8 unbroken sets", rd_data[5], 1'b1);
      do_wr(8'h51);
      kick();
      do_tick(QUAL + 1);
      check("R8 once per condition", rd_data[5], 1'b0);
      bus_cond = 1'b0; step();

      // R9 set beats same-cycle clear
      do_wr(8'h51);
      kick();
      bus_cond = 1'b1; do_tick(QUAL - 1);
      tick = 1'b1; wr_en = 1'b1; wr_data = 8'h51; step();
      tick = 1'b0; wr_en = 1'b0;
      check("R9 set beats clear", rd_data, 8'h21);
      bus_cond = 1'b0; step();

      // R6 expiry sweep
      for (int n = 1; n <= WDT; n++) begin
         kick();
         do_wr(8'h31);
         do_tick(n);
         check($sformatf("R6 ticks %0d", n), rd_data[6], (n >= WDT) ? 1'b1 : 1'b0);
      end
      check("R6 value keeps bus", rd_data, 8'h61);

      // R2 halt, then R6 expiry clears everything it owns
      irq_req = 1'b1; step(); irq_req = 1'b0;
      ei_stb = 1'b1; step(); ei_stb = 1'b0;
      halt_stb = 1'b1; step(); halt_stb = 1'b0;
      check("R2 halt clears run", rd_data, 8'hE4);
      check("R2 halted", cpu_halt, 1'b1);
      do_wr(8'h71);
      check("R2 write 1 no restart", rd_data, 8'hE4);
      kick();
      do_tick(WDT);
      check("R6 full load", rd_data, 8'h61);
      check("R2 reset restarts", cpu_halt, 1'b0);

      // R7 kick
      do_wr(8'h31);
      kick(); do_tick(WDT - 1);
      kick(); do_tick(WDT - 1);
      tick = 1'b1; wdt_kick = 1'b1; step(); tick = 1'b0; wdt_kick = 1'b0;
      do_tick(WDT - 1);
      check("R7 kicks prevent expiry", rd_data, 8'h21);
      do_tick(1);
      check("R7 expiry after kick", rd_data, 8'h61);

      // R4/R5 suspend with later bus wake
      do_wr(8'h31);
      kick();
      do_wr(8'h79);
      check("R4 clock stop", clk_stop_req, 1'b1);
      check("R4 suspend bit", rd_data, 8'h29);
      check("R4 halted", cpu_halt, 1'b1);
      do_tick(WDT + 4);
      check("R7 frozen in sleep", rd_data, 8'h29);
      check("R5 stays asleep", clk_stop_req, 1'b1);
      wake_bus = 1'b1; step(); wake_bus = 1'b0;
      check("R5 clock released", clk_stop_req, 1'b0);
      check("R5 still suspended", rd_data, 8'h29);
      do_tick(START - 1);
      check("R5 startup pending", cpu_halt, 1'b1);
      do_tick(1);
      check("R5 resumed", rd_data, 8'h21);
      check("R5 running", cpu_halt, 1'b0);

      // R5 wake already present
      kick();
      wake_irq = 1'b1;
      do_wr(8'h79);
      check("R5 entered anyway", clk_stop_req, 1'b1);
      step();
      check("R5 one cycle stop", clk_stop_req, 1'b0);
      check("R5 in startup", rd_data, 8'h29);
      wake_irq = 1'b0;
      do_tick(START);
      check("R5 resumed after present wake", rd_data, 8'h21);

      // R1 reset mid-run, then R6 keeps bit4
      por_n = 1'b0; step(); por_n = 1'b1; step();
      check("R1 reset again", rd_data, 8'h11);
      kick();
      do_tick(WDT);
      check("R6 keeps bit4", rd_data, 8'h51);

      // Coincident watchdog expiry and bus event
      do_wr(8'h01);
      kick();
      do_tick(WDT - QUAL);
      bus_cond = 1'b1;
      do_tick(QUAL);
      check("R6 R8 coincide", rd_data, 8'h61);
      bus_cond = 1'b0; step();

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule